// File: doc/BRIEF.md
# Interval Timer with Snapshot Capture

This block is a 32-bit down-counting interval timer that sits on a simple register bus with 16-bit data. Software programs the timeout interval as two 16-bit halves, picks one-shot or continuous operation, and starts or stops counting with strobe bits in the control word. When the count runs out, a sticky timeout flag is set. If the interrupt is enabled, this flag drives a level interrupt until software clears it.

The count is 32 bits wide and the bus is only 16 bits wide. To read the live count coherently, software writes to the snapshot-low register, which freezes the whole count in a snapshot latch. Software then reads the two frozen halves at its own pace. Reads are combinational and return data in the same cycle the read is presented. Writes take effect at the next rising clock edge.

Top module: `ival_timer`

## Requirements
- R1: After synchronous reset:
  - the timer is stopped;
  - the period and the counter are all ones;
  - the interrupt enable, continuous mode and the timeout flag are clear;
  - the snapshot is zero.
- R2: `bus_addr` is a word index (byte offset divided by four):
  - 0 = status, 1 = control, 2 = period bits 15:0, 3 = period bits 31:16, 4 = snapshot bits 15:0, 5 = snapshot bits 31:16.
  - Indices 6 and 7 read as zero.
  - `bus_rdata` is zero when no read is presented.
- R3: Control bit 0 enables the interrupt and bit 1 selects continuous mode; both read back. Control bits 2 and above read as zero.
- R4: Control bit 2 is a start strobe that sets the timer running. Control bit 3 is a stop strobe that halts it. Neither strobe is stored. When both are written together, stop wins. A strobe also overrides a one-shot timeout in the same cycle.
- R5: Writing either period half does three things: it stops the timer, it updates that half, and it loads the counter with the new 32-bit period {high, low}. Counting resumes only on a start strobe.
- R6: While running, the counter decrements once per clock. A timeout occurs in a cycle where the counter is zero and the timer runs. From a start with period P, the first timeout is registered P+1 edges later, and consecutive timeouts are P+1 cycles apart.
- R7: On a timeout the counter reloads from the period. In continuous mode it keeps running. In one-shot mode it stops, unless a start strobe arrives in that same cycle.
- R8: Status has two bits:
  - bit 0 is the sticky timeout flag;
  - bit 1 shows whether the timer is running;
  - all other bits read as zero.
  Any write to status clears the flag, but a timeout in the same cycle keeps it set.
- R9: `irq_o` is high exactly when the timeout flag is set and the interrupt enable is set. It rises one edge after a timeout cycle when the interrupt is enabled.
- R10: A write to snapshot-low captures the counter value as it stood before that edge. A write to snapshot-high is ignored and leaves the snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is due in the same cycle as the read request, with no register in the path. The bench therefore samples `bus_rdata` shortly after driving the request on the falling edge, before the next rising edge. Every write, count step, timeout, reload and flag change becomes visible one rising edge after the cycle that caused it, and `irq_o` follows the registered flag with no further delay. The bench keeps a requirement-level model that advances exactly once per rising edge, and it compares `irq_o` just after each rising edge. Directed checks cover several exact cases:
- a period of 4 gives a timeout on the fifth edge;
- a period of 0 gives a timeout on every edge;
- a snapshot returns the pre-edge count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register word indices; the bus address is byte offset / 4.
    typedef enum logic [2:0] {
        REG_STATUS  = 3'd0,
        REG_CTRL    = 3'd1,
        REG_PER_LO  = 3'd2,
        REG_PER_HI  = 3'd3,
        REG_SNAP_LO = 3'd4,
        REG_SNAP_HI = 3'd5
    } reg_idx_e;

    localparam int REG_IDX_W = 3;

    // Control word bit positions
    localparam int CTL_IEN   = 0;
    localparam int CTL_CONT  = 1;
    localparam int CTL_START = 2;
    localparam int CTL_STOP  = 3;
    localparam int CTL_W     = 4;

    // Status word bit positions
    localparam int STS_TMO = 0;
    localparam int STS_RUN = 1;

    // Persistent configuration held by the control register
    typedef struct packed {
        logic irq_en;
        logic cont;
    } tmr_cfg_t;

    // One-hot style write strobes decoded from a bus access
    typedef struct packed {
        logic status;
        logic ctrl;
        logic per_lo;
        logic per_hi;
        logic snap_lo;
    } tmr_wr_t;

    // Turns one bus access into per-register write strobes.
    function automatic tmr_wr_t decode_write(logic sel, logic we,
                                             logic [REG_IDX_W-1:0] idx);
        tmr_wr_t w;
        logic    en;
        en        = sel && we;
        w.status  = en && (idx == REG_STATUS);
        w.ctrl    = en && (idx == REG_CTRL);
        w.per_lo  = en && (idx == REG_PER_LO);
        w.per_hi  = en && (idx == REG_PER_HI);
        w.snap_lo = en && (idx == REG_SNAP_LO);
        return w;
    endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
(
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [REG_IDX_W-1:0]  bus_addr,
    input  logic [CTL_W-1:0]      ctl_bits,
    output tmr_wr_t               wr_o,
    output logic                  rd_en_o,
    output logic                  start_o,
    output logic                  stop_o,
    output tmr_cfg_t              cfg_wdata_o
);

    always_comb begin
        wr_o               = decode_write(bus_sel, bus_we, bus_addr);
        rd_en_o            = bus_sel && !bus_we;
        start_o            = wr_o.ctrl && ctl_bits[CTL_START];
        stop_o             = wr_o.ctrl && ctl_bits[CTL_STOP];
        cfg_wdata_o.irq_en = ctl_bits[CTL_IEN];
        cfg_wdata_o.cont   = ctl_bits[CTL_CONT];
    end

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CNT_W = 2 * DATA_W,
    localparam int N_HALF = CNT_W / DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tmr_wr_t               wr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  tmr_cfg_t              cfg_wdata_i,
    input  logic                  rd_en_i,
    input  logic [REG_IDX_W-1:0]  rd_idx_i,
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic                  run_i,
    input  logic                  flag_i,
    output tmr_cfg_t              cfg_o,
    output logic [CNT_W-1:0]      period_o,
    output logic [CNT_W-1:0]      period_next_o,
    output logic [DATA_W-1:0]     rdata_o
);

    logic [DATA_W-1:0] per_half_q [N_HALF];
    logic [DATA_W-1:0] per_half_d [N_HALF];
    tmr_cfg_t          cfg_q;
    logic [CNT_W-1:0]  snap_q;

    // Period halves: one register per half, low half first
    for (genvar h = 0; h < N_HALF; h++) begin : g_per_half
        logic half_we;
        assign half_we       = (h == 0) ? wr_i.per_lo : wr_i.per_hi;
        assign per_half_d[h] = half_we ? wdata_i : per_half_q[h];

        always_ff @(posedge clk) begin
            if (rst) per_half_q[h] <= '1;
            else     per_half_q[h] <= per_half_d[h];
        end

        assign period_o[h*DATA_W +: DATA_W]      = per_half_q[h];
        assign period_next_o[h*DATA_W +: DATA_W] = per_half_d[h];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            snap_q <= '0;
        end else begin
            if (wr_i.ctrl)    cfg_q  <= cfg_wdata_i;
            if (wr_i.snap_lo) snap_q <= cnt_i;
        end
    end

    assign cfg_o = cfg_q;

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (rd_idx_i)
                REG_STATUS: begin
                    rdata_o[STS_TMO] = flag_i;
                    rdata_o[STS_RUN] = run_i;
                end
                REG_CTRL: begin
                    rdata_o[CTL_IEN]  = cfg_q.irq_en;
                    rdata_o[CTL_CONT] = cfg_q.cont;
                end
                REG_PER_LO:  rdata_o = per_half_q[0];
                REG_PER_HI:  rdata_o = per_half_q[1];
                REG_SNAP_LO: rdata_o = snap_q[DATA_W-1:0];
                REG_SNAP_HI: rdata_o = snap_q[CNT_W-1:DATA_W];
                default:     rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             tmo_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             run_q, run_d;
    logic             tmo;

    always_comb begin
        tmo   = run_q && (cnt_q == '0);
        cnt_d = cnt_q;
        run_d = run_q;
        if (run_q) cnt_d = tmo ? period_i : (cnt_q - CNT_ONE);
        if (tmo && !cont_i) run_d = 1'b0;
        if (start_i) run_d = 1'b1;
        if (stop_i)  run_d = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
            run_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign cnt_o = cnt_q;
    assign run_o = run_q;
    assign tmo_o = tmo;

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic tmo_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q, flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (tmo_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/ival_timer.sv
module ival_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [2:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_o
);

    localparam int CNT_W = 2 * DATA_W;

    tmr_wr_t          wr_w;
    tmr_cfg_t         cfg_wdata_w;
    tmr_cfg_t         cfg_w;
    logic             rd_en_w;
    logic             start_w;
    logic             stop_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] period_w;
    logic [CNT_W-1:0] period_next_w;
    logic             run_w;
    logic             tmo_w;
    logic             flag_w;

    tmr_bus_decode u_dec (
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .ctl_bits    (bus_wdata[CTL_W-1:0]),
        .wr_o        (wr_w),
        .rd_en_o     (rd_en_w),
        .start_o     (start_w),
        .stop_o      (stop_w),
        .cfg_wdata_o (cfg_wdata_w)
    );

    tmr_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_i          (wr_w),
        .wdata_i       (bus_wdata),
        .cfg_wdata_i   (cfg_wdata_w),
        .rd_en_i       (rd_en_w),
        .rd_idx_i      (bus_addr),
        .cnt_i         (cnt_w),
        .run_i         (run_w),
        .flag_i        (flag_w),
        .cfg_o         (cfg_w),
        .period_o      (period_w),
        .period_next_o (period_next_w),
        .rdata_o       (bus_rdata)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_w.per_lo || wr_w.per_hi),
        .load_val_i (period_next_w),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .cont_i     (cfg_w.cont),
        .period_i   (period_w),
        .cnt_o      (cnt_w),
        .run_o      (run_w),
        .tmo_o      (tmo_w)
    );

    tmr_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .tmo_i  (tmo_w),
        .clr_i  (wr_w.status),
        .flag_o (flag_w)
    );

    assign irq_o = flag_w && cfg_w.irq_en;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic             stop_bit,
    input logic             irq_o,
    input logic             run,
    input logic             flag,
    input logic             ien,
    input logic             cont,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic wr_any, wr_status, wr_ctrl, wr_per, at_zero;
    assign wr_any    = bus_sel && bus_we;
    assign wr_status = wr_any && (bus_addr == 3'd0);
    assign wr_ctrl   = wr_any && (bus_addr == 3'd1);
    assign wr_per    = wr_any && (bus_addr == 3'd2 || bus_addr == 3'd3);
    assign at_zero   = run && (cnt == '0);

    // R4: a stop strobe always leaves the timer halted
    a_r4_stop_halts: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && stop_bit) |=> !run);

    // R5: period write halts and loads the new period
    a_r5_period_load: assert property (@(posedge clk) disable iff (rst)
        wr_per |=> (!run && cnt == period));

    // R6: running counter steps down by one away from zero
    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != '0 && !wr_per) |=> (cnt == $past(cnt) - ONE));

    // R6: a zero count while running sets the flag
    a_r6_timeout_flag: assert property (@(posedge clk) disable iff (rst)
        at_zero |=> flag);

    // R7: one-shot timeout without a new start stops the timer
    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !cont && !wr_ctrl && !wr_per) |=> !run);

    // R8: flag is sticky until a status write
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_status) |=> flag);

    // R8: status write clears the flag when no timeout collides
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_status && !at_zero) |=> !flag);

    // R9: enabled timeout raises the interrupt one edge later
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
        (at_zero && ien && !wr_ctrl) |=> irq_o);

endmodule

bind ival_timer tmr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .stop_bit (bus_wdata[3]),
    .irq_o    (irq_o),
    .run      (run_w),
    .flag     (flag_w),
    .ien      (cfg_w.irq_en),
    .cont     (cfg_w.cont),
    .cnt      (cnt_w),
    .period   (period_w)
);

// File: tb/tb_ival_timer.sv
module tb_ival_timer;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 32'h5EED_0A1;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_we;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ival_timer dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Requirement-level model state
    logic [31:0] m_cnt, m_per, m_snap;
    logic        m_run, m_ien, m_cont, m_flag;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(logic [2:0] a);
        case (a)
            3'd0: return {14'd0, m_run, m_flag};
            3'd1: return {14'd0, m_cont, m_ien};
            3'd2: return m_per[15:0];
            3'd3: return m_per[31:16];
            3'd4: return m_snap[15:0];
            3'd5: return m_snap[31:16];
            default: return 16'd0;
        endcase
    endfunction

    function automatic string read_tag(logic [2:0] a);
        case (a)
            3'd0: return "R8";
            3'd1: return "R3";
            3'd2, 3'd3: return "R5";
            3'd4, 3'd5: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = '1; m_per = '1; m_snap = '0;
        m_run = 0; m_ien = 0; m_cont = 0; m_flag = 0;
    endtask

    task automatic model_edge(logic s, logic w, logic [2:0] a, logic [15:0] d);
        logic        wr, tmo;
        logic [31:0] n_cnt, n_per;
        logic        n_run, n_flag;
        wr    = s && w;
        tmo   = m_run && (m_cnt == 0);
        n_per = m_per;
        n_cnt = m_cnt;
        n_run = m_run;
        n_flag = m_flag;
        if (wr && a == 3'd2) n_per[15:0]  = d;
        if (wr && a == 3'd3) n_per[31:16] = d;
        if (m_run) n_cnt = tmo ? m_per : m_cnt - 1;
        if (tmo && !m_cont) n_run = 0;
        if (wr && a == 3'd1 && d[2]) n_run = 1;
        if (wr && a == 3'd1 && d[3]) n_run = 0;
        if (wr && (a == 3'd2 || a == 3'd3)) begin
            n_cnt = n_per;
            n_run = 0;
        end
        if (wr && a == 3'd0) n_flag = 0;
        if (tmo) n_flag = 1;
        if (wr && a == 3'd4) m_snap = m_cnt;
        if (wr && a == 3'd1) begin
            m_ien  = d[0];
            m_cont = d[1];
        end
        m_per = n_per; m_cnt = n_cnt; m_run = n_run; m_flag = n_flag;
    endtask

    task automatic step(logic s, logic w, logic [2:0] a, logic [15:0] d, string tag);
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
        #1;
        if (s && !w)
            check((tag == "") ? read_tag(a) : tag, {16'd0, bus_rdata}, {16'd0, model_read(a)});
        @(posedge clk);
        model_edge(s, w, a, d);
        #1;
        check((tag == "") ? "R9" : tag, {31'd0, irq_o}, {31'd0, m_flag && m_ien});
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d, string tag);
        step(1, 1, a, d, tag);
    endtask

    task automatic rd(logic [2:0] a, string tag);
        step(1, 0, a, 16'd0, tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 16'd0, tag);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6: watchdog expired actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(SEED);
        rst = 1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();

        // R1: reset state
        #1 check("R1", {31'd0, irq_o}, 32'd0);
        rd(3'd0, "R1");
        rd(3'd1, "R1");
        rd(3'd2, "R1");
        rd(3'd3, "R1");
        rd(3'd4, "R1");
        wr(3'd4, 16'd0, "R1");
        rd(3'd4, "R1");
        rd(3'd5, "R1");
        check("R1", m_snap, 32'hFFFF_FFFF);

        // R5/R6: period 4, continuous, interrupt on
        wr(3'd2, 16'd4, "R5");
        rd(3'd3, "R5");
        wr(3'd3, 16'd0, "R5");
        wr(3'd1, 16'h0007, "R4");
        idle(4, "R6");
        check("R6", {31'd0, irq_o}, 32'd0);
        idle(1, "R6");
        check("R6", {31'd0, irq_o}, 32'd1);
        wr(3'd0, 16'd0, "R8");
        check("R8", {31'd0, irq_o}, 32'd0);
        idle(3, "R7");
        check("R7", {31'd0, irq_o}, 32'd0);
        idle(1, "R7");
        check("R7", {31'd0, irq_o}, 32'd1);

        // R7: one-shot stops after its timeout
        wr(3'd1, 16'h0005, "R7");
        idle(10, "R7");
        rd(3'd0, "R7");
        check("R7", {31'd0, m_run}, 32'd0);

        // R4/R3: both strobes, stop wins; strobes read zero
        wr(3'd0, 16'hFFFF, "R8");
        wr(3'd1, 16'h000E, "R4");
        rd(3'd0, "R4");
        rd(3'd1, "R3");
        wr(3'd1, 16'h0004, "R4");
        rd(3'd0, "R4");

        // R5: period write halts and reloads
        wr(3'd2, 16'd7, "R5");
        rd(3'd0, "R5");
        wr(3'd4, 16'd0, "R10");
        rd(3'd4, "R10");

        // R10: snapshot of a running count; high write ignored
        wr(3'd1, 16'h0006, "R4");
        idle(2, "R6");
        wr(3'd4, 16'd0, "R10");
        rd(3'd4, "R10");
        check("R10", m_snap, 32'd5);
        wr(3'd5, 16'h1234, "R10");
        rd(3'd4, "R10");
        rd(3'd5, "R10");

        // R8: period zero, clear collides with timeout
        wr(3'd2, 16'd0, "R6");
        wr(3'd1, 16'h0007, "R6");
        idle(1, "R6");
        wr(3'd0, 16'd0, "R8");
        check("R8", {31'd0, irq_o}, 32'd1);
        wr(3'd1, 16'h0009, "R4");
        wr(3'd0, 16'd0, "R8");
        check("R8", {31'd0, irq_o}, 32'd0);

        // R2: unmapped indices read zero
        rd(3'd6, "R2");
        rd(3'd7, "R2");
        wr(3'd6, 16'hFFFF, "R2");
        rd(3'd1, "R2");

        // Random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            int unsigned op;
            op = $urandom % 16;
            if (op < 8)        idle(1, "");
            else if (op < 11)  rd(3'($urandom % 8), "");
            else if (op == 11) wr(3'd1, 16'($urandom % 16), "");
            else if (op == 12) wr(3'd2, 16'($urandom % 20), "");
            else if (op == 13) wr(3'd3, (($urandom % 8) == 0) ? 16'd1 : 16'd0, "");
            else if (op == 14) wr(($urandom % 2) ? 3'd0 : 3'd4, 16'($urandom), "");
            else               wr(3'd5, 16'($urandom), "");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule